// File: doc/BRIEF.md
# Flash Address-Mode and Protection Configuration Register

This block holds the third configuration byte of a serial NOR flash device model. The byte contains five fields. The first is the address mode currently in use. The second is the address mode the device takes after a reset. The third selects which write-protect scheme applies. The fourth chooses the function of the hold/reset pin. The fifth sets the output drive strength. A command decoder ahead of the block delivers single-cycle strobes: arm for non-volatile write, arm for volatile write, write configuration, enter 4-byte mode, leave 4-byte mode and soft device reset. A write-configuration strobe comes with one data byte.

The block keeps two copies of the fields. The non-volatile copy lasts across a soft reset and changes only through an armed non-volatile write. The working copy drives the outputs. The current address mode cannot be written directly. It is set from the stored power-up mode at every reset, and after that only the enter and leave commands change it. In 3-byte mode, a neighbouring address path supplies the top address byte from its own extended-address register.

When the protect-select field is 0, protection comes from range bits kept elsewhere. When it is 1, protection comes from individual block locks. The block gives the block-lock array a one-cycle pulse after every reset so that the array sets all of its locks.

Top module: `fcfg_mode_reg`

## Requirements
- R1: The readback byte `cfg_rd_o` has this layout. Bit 7 is the hold/reset select. Bits 6:5 are the drive strength. Bits 4:3 always read 0. Bit 2 is the protect select. Bit 1 is the stored power-up address mode. Bit 0 is the current address mode, where 0 means 3-byte and 1 means 4-byte.
- R2: After `rst`, both copies hold the parameter `DEF_CFG` with bits 4:3 and bit 0 dropped. Bit 0 equals `DEF_CFG[1]`. With the default `8'h60`, the readback is `8'h60` and `addr_bytes_o` is 3.
- R3: `enter4_i` sets bit 0 and `exit4_i` clears it. Neither changes any other readback bit. `addr_bytes_o` is 4 when bit 0 is 1 and 3 when bit 0 is 0.
- R4: `wr_cfg_i` after `arm_nv_i` loads bits 7, 6, 5, 2 and 1 of `wr_data_i` into both copies. Data bits 4:3 and bit 0 are discarded, and the current mode is kept.
- R5: `wr_cfg_i` is ignored when the previous strobe was not an arm strobe. Each arm is cleared by a write-configuration strobe, by `enter4_i`, by `exit4_i` or by `soft_rst_i`.
- R6: `wr_cfg_i` after `arm_vol_i` loads bits 7, 6, 5 and 2 into the working copy only. Bit 1 and the non-volatile copy do not change.
- R7: `soft_rst_i` copies the non-volatile fields into the working copy and loads bit 0 from the stored power-up mode. The non-volatile copy is kept.
- R8: `lock_init_o` is 1 in the cycle after any cycle in which `rst` or `soft_rst_i` is sampled high. At all other times it is 0.
- R9: `prot_blk_sel_o` equals the working protect-select bit, which is readback bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous power-on reset to factory state, active high |
| soft_rst_i | input | 1 | Device soft-reset command strobe |
| arm_nv_i | input | 1 | Arm a non-volatile configuration write |
| arm_vol_i | input | 1 | Arm a volatile configuration write |
| wr_cfg_i | input | 1 | Write-configuration command strobe |
| wr_data_i | input | 8 | Data byte carried with the write strobe |
| enter4_i | input | 1 | Enter 4-byte addressing strobe |
| exit4_i | input | 1 | Leave 4-byte addressing strobe |
| cfg_rd_o | output | 8 | Readback byte |
| addr_bytes_o | output | 3 | Active address width in bytes (3 or 4) |
| prot_blk_sel_o | output | 1 | 1 means per-block locks, 0 means range protection |
| drv_o | output | 2 | Working drive-strength field |
| hold_sel_o | output | 1 | Working hold/reset pin select |
| lock_init_o | output | 1 | One-cycle pulse telling the lock array to set all locks |

## Verification
The bench uses the default `DEF_CFG` of `8'h60`. That value starts the device in 3-byte mode with range protection, so each armed write visibly flips bits away from the reset state. The bench sweeps all 256 data bytes through both the non-volatile and the volatile write paths. After each write it applies a soft reset, so every combination of reserved and writable bits is checked on readback, and the reload of the current mode is checked from both stored values. It also covers unarmed writes, double writes after one arm, and arms cancelled by mode commands.

// File: rtl/fcfg_pkg.sv
package fcfg_pkg;
    localparam int CFG_W      = 8;
    localparam int BIT_ADS    = 0;
    localparam int BIT_ADP    = 1;
    localparam int BIT_WPS    = 2;
    localparam int BIT_DRV_LO = 5;
    localparam int BIT_HOLD   = 7;
    localparam int DRV_W      = 2;
    localparam int ADDR_NARROW = 3;
    localparam int ADDR_WIDE   = 4;

    typedef enum logic [1:0] {
        ARM_NONE = 2'd0,
        ARM_NV   = 2'd1,
        ARM_VOL  = 2'd2
    } arm_e;

    typedef struct packed {
        logic             hold;
        logic [DRV_W-1:0] drv;
        logic             wps;
    } work_t;

    function automatic work_t work_from_byte(input logic [CFG_W-1:0] b);
        work_t w;
        w.hold = b[BIT_HOLD];
        w.drv  = b[BIT_DRV_LO +: DRV_W];
        w.wps  = b[BIT_WPS];
        return w;
    endfunction

    function automatic logic [CFG_W-1:0] pack_rd(input work_t w, input logic adp, input logic ads);
        logic [CFG_W-1:0] r;
        r = '0;
        r[BIT_HOLD]             = w.hold;
        r[BIT_DRV_LO +: DRV_W]  = w.drv;
        r[BIT_WPS]              = w.wps;
        r[BIT_ADP]              = adp;
        r[BIT_ADS]              = ads;
        return r;
    endfunction
endpackage

// File: rtl/fcfg_arm.sv
module fcfg_arm
    import fcfg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic soft_rst,
    input  logic arm_nv,
    input  logic arm_vol,
    input  logic wr_cfg,
    input  logic enter4,
    input  logic exit4,
    output logic commit_nv,
    output logic commit_vol
);
    arm_e arm_q;

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            arm_q <= ARM_NONE;
        end else if (wr_cfg || enter4 || exit4) begin
            arm_q <= ARM_NONE;
        end else if (arm_nv) begin
            arm_q <= ARM_NV;
        end else if (arm_vol) begin
            arm_q <= ARM_VOL;
        end
    end

    always_comb begin
        commit_nv  = wr_cfg && !soft_rst && (arm_q == ARM_NV);
        commit_vol = wr_cfg && !soft_rst && (arm_q == ARM_VOL);
    end

    AST_ARM_CLEARED: assert property (@(posedge clk) disable iff (rst)
        $past(wr_cfg) |-> (arm_q == ARM_NONE)); // R5
    AST_ONE_COMMIT: assert property (@(posedge clk) disable iff (rst)
        !(commit_nv && commit_vol)); // R5
endmodule

// File: rtl/fcfg_shadow.sv
module fcfg_shadow
    import fcfg_pkg::*;
#(
    parameter logic [CFG_W-1:0] DEF_CFG = 8'h60
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             commit_nv,
    input  logic [CFG_W-1:0] data,
    output work_t            sh_work,
    output logic             sh_adp
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sh_work <= work_from_byte(DEF_CFG);
            sh_adp  <= DEF_CFG[BIT_ADP];
        end else if (commit_nv) begin
            sh_work <= work_from_byte(data);
            sh_adp  <= data[BIT_ADP];
        end
    end

    AST_ADP_NEEDS_ARM: assert property (@(posedge clk) disable iff (rst)
        !$stable(sh_adp) |-> $past(commit_nv)); // R4
    AST_SHADOW_VOL_SAFE: assert property (@(posedge clk) disable iff (rst)
        !$stable(sh_work) |-> $past(commit_nv)); // R6
endmodule

// File: rtl/fcfg_live.sv
module fcfg_live
    import fcfg_pkg::*;
#(
    parameter logic [CFG_W-1:0] DEF_CFG = 8'h60
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             soft_rst,
    input  logic             commit_nv,
    input  logic             commit_vol,
    input  logic [CFG_W-1:0] data,
    input  logic             enter4,
    input  logic             exit4,
    input  work_t            sh_work,
    input  logic             sh_adp,
    output work_t            wk,
    output logic             ads,
    output logic             lock_init
);
    always_ff @(posedge clk) begin
        if (rst) begin
            wk  <= work_from_byte(DEF_CFG);
            ads <= DEF_CFG[BIT_ADP];
        end else if (soft_rst) begin
            wk  <= sh_work;
            ads <= sh_adp;
        end else begin
            if (commit_nv || commit_vol) begin
                wk <= work_from_byte(data);
            end
            if (enter4) begin
                ads <= 1'b1;
            end else if (exit4) begin
                ads <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        lock_init <= rst || soft_rst;
    end

    AST_ADS_CMD_ONLY: assert property (@(posedge clk) disable iff (rst)
        !$stable(ads) |-> $past(enter4 || exit4 || soft_rst)); // R3
    AST_WORK_CHANGE: assert property (@(posedge clk) disable iff (rst)
        !$stable(wk) |-> $past(commit_nv || commit_vol || soft_rst)); // R6
    AST_LOCK_PULSE: assert property (@(posedge clk) disable iff (rst)
        $past(soft_rst) |-> lock_init); // R8
    AST_RELOAD_ADS: assert property (@(posedge clk) disable iff (rst)
        $past(soft_rst) |-> (ads == $past(sh_adp))); // R7
endmodule

// File: rtl/fcfg_mode_reg.sv
module fcfg_mode_reg
    import fcfg_pkg::*;
#(
    parameter logic [CFG_W-1:0] DEF_CFG = 8'h60
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             soft_rst_i,
    input  logic             arm_nv_i,
    input  logic             arm_vol_i,
    input  logic             wr_cfg_i,
    input  logic [CFG_W-1:0] wr_data_i,
    input  logic             enter4_i,
    input  logic             exit4_i,
    output logic [CFG_W-1:0] cfg_rd_o,
    output logic [2:0]       addr_bytes_o,
    output logic             prot_blk_sel_o,
    output logic [DRV_W-1:0] drv_o,
    output logic             hold_sel_o,
    output logic             lock_init_o
);
    logic  commit_nv, commit_vol;
    work_t sh_work, wk;
    logic  sh_adp, ads;

    fcfg_arm u_arm (
        .clk(clk), .rst(rst), .soft_rst(soft_rst_i),
        .arm_nv(arm_nv_i), .arm_vol(arm_vol_i), .wr_cfg(wr_cfg_i),
        .enter4(enter4_i), .exit4(exit4_i),
        .commit_nv(commit_nv), .commit_vol(commit_vol)
    );

    fcfg_shadow #(.DEF_CFG(DEF_CFG)) u_shadow (
        .clk(clk), .rst(rst), .commit_nv(commit_nv), .data(wr_data_i),
        .sh_work(sh_work), .sh_adp(sh_adp)
    );

    fcfg_live #(.DEF_CFG(DEF_CFG)) u_live (
        .clk(clk), .rst(rst), .soft_rst(soft_rst_i),
        .commit_nv(commit_nv), .commit_vol(commit_vol), .data(wr_data_i),
        .enter4(enter4_i), .exit4(exit4_i),
        .sh_work(sh_work), .sh_adp(sh_adp),
        .wk(wk), .ads(ads), .lock_init(lock_init_o)
    );

    always_comb begin
        cfg_rd_o       = pack_rd(wk, sh_adp, ads);
        addr_bytes_o   = ads ? 3'(ADDR_WIDE) : 3'(ADDR_NARROW);
        prot_blk_sel_o = wk.wps;
        drv_o          = wk.drv;
        hold_sel_o     = wk.hold;
    end

    AST_WIDTH_TRACKS_MODE: assert property (@(posedge clk) disable iff (rst)
        $past(enter4_i && !soft_rst_i) |-> (addr_bytes_o == 3'd4)); // R3
    AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        $past(wr_cfg_i) |-> (cfg_rd_o[4:3] == 2'b00)); // R1
endmodule

// File: tb/fcfg_mode_reg_tb.sv
module fcfg_mode_reg_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       soft_rst_i = 0, arm_nv_i = 0, arm_vol_i = 0, wr_cfg_i = 0;
    logic       enter4_i = 0, exit4_i = 0;
    logic [7:0] wr_data_i = 8'h00;
    logic [7:0] cfg_rd_o;
    logic [2:0] addr_bytes_o;
    logic       prot_blk_sel_o, hold_sel_o, lock_init_o;
    logic [1:0] drv_o;

    int n_cmp = 0;
    int n_bad = 0;

    // model state: working {hold,drv1,drv0,wps}, shadow same, shadow power-up mode, current mode
    logic [3:0] m_wk, m_sh;
    logic       m_adp, m_ads;

    always #2 clk = ~clk;

    fcfg_mode_reg u_dut (
        .clk(clk), .rst(rst), .soft_rst_i(soft_rst_i), .arm_nv_i(arm_nv_i),
        .arm_vol_i(arm_vol_i), .wr_cfg_i(wr_cfg_i), .wr_data_i(wr_data_i),
        .enter4_i(enter4_i), .exit4_i(exit4_i), .cfg_rd_o(cfg_rd_o),
        .addr_bytes_o(addr_bytes_o), .prot_blk_sel_o(prot_blk_sel_o),
        .drv_o(drv_o), .hold_sel_o(hold_sel_o), .lock_init_o(lock_init_o)
    );

    function automatic logic [7:0] exp_rd();
        return {m_wk[3:1], 2'b00, m_wk[0], m_adp, m_ads};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_all(input string req);
        chk(req, {24'h0, cfg_rd_o}, {24'h0, exp_rd()});
        chk("R3", {29'h0, addr_bytes_o}, m_ads ? 32'd4 : 32'd3);
        chk("R9", {31'h0, prot_blk_sel_o}, {31'h0, m_wk[0]});
        chk("R1", {29'h0, hold_sel_o, drv_o}, {29'h0, m_wk[3:1]});
    endtask

    // drive one strobe for a single cycle; outputs are settled at return
    task automatic pulse(input int which, input logic [7:0] d);
        wr_data_i = d;
        case (which)
            0: arm_nv_i = 1;
            1: arm_vol_i = 1;
            2: wr_cfg_i = 1;
            3: enter4_i = 1;
            4: exit4_i = 1;
            default: soft_rst_i = 1;
        endcase
        @(negedge clk);
        {arm_nv_i, arm_vol_i, wr_cfg_i, enter4_i, exit4_i, soft_rst_i} = '0;
    endtask

    task automatic do_soft();
        pulse(5, 8'h00);
        m_wk = m_sh; m_ads = m_adp;
        chk("R8", {31'h0, lock_init_o}, 32'd1);
        chk_all("R7");
        @(negedge clk);
        chk("R8", {31'h0, lock_init_o}, 32'd0);
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst = 0;
        m_wk = 4'b0110; m_sh = 4'b0110; m_adp = 0; m_ads = 0;
        chk("R8", {31'h0, lock_init_o}, 32'd1);
        chk_all("R2");
        chk("R2", {24'h0, cfg_rd_o}, 32'h60);
        @(negedge clk);
        chk("R8", {31'h0, lock_init_o}, 32'd0);

        // unarmed write is ignored
        pulse(2, 8'hFF);
        chk_all("R5");
        // enter/exit touch bit 0 only
        pulse(3, 8'h00); m_ads = 1; chk_all("R3");
        pulse(4, 8'h00); m_ads = 0; chk_all("R3");
        // arm cancelled by a mode command
        pulse(0, 8'h00); pulse(3, 8'h00); m_ads = 1;
        pulse(2, 8'hFF); chk_all("R5");
        // arm consumed by first write
        pulse(0, 8'h00); pulse(2, 8'h84);
        m_wk = 4'b1001; m_sh = 4'b1001; m_adp = 0; chk_all("R4");
        pulse(2, 8'h7B); chk_all("R5");
        // arm cancelled by soft reset
        pulse(0, 8'h00); do_soft();
        pulse(2, 8'hFF); chk_all("R5");

        // non-volatile sweep
        for (int d = 0; d < 256; d++) begin
            pulse(0, 8'h00);
            pulse(2, 8'(d));
            m_wk = {d[7], d[6], d[5], d[2]}; m_sh = m_wk; m_adp = d[1];
            chk_all("R4");
            if (d[0]) begin pulse(3, 8'h00); m_ads = 1; end
            else      begin pulse(4, 8'h00); m_ads = 0; end
            chk_all("R3");
            do_soft();
        end

        // volatile sweep over a stored base
        pulse(0, 8'h00); pulse(2, 8'h22);
        m_wk = 4'b0010; m_sh = 4'b0010; m_adp = 1; chk_all("R4");
        for (int d = 0; d < 256; d++) begin
            pulse(1, 8'h00);
            pulse(2, 8'(d));
            m_wk = {d[7], d[6], d[5], d[2]};
            chk_all("R6");
            pulse(2, ~8'(d));
            chk_all("R5");
            do_soft();
            chk("R6", {24'h0, cfg_rd_o}, 32'h23);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule